// File: doc/BRIEF.md
# Thermal Event Output Controller

This block turns a signed temperature sample and three limits (upper, lower, critical) into a single event pin. A small configuration register controls the pin. It is written and read over a simple register bus made of a write enable, an address, write data and combinational read data. The register sets whether the event follows the temperature condition or is held until software clears it. It also sets the asserted level of the pin, gates the pin on or off, and can restrict the event to critical temperatures only.

The register also holds a read-only status bit that mirrors the pin's asserted state. It has a self-clearing clear command and two sticky lock bits. Once either lock is set, the mode and level fields can no longer be changed until reset. The internal event flag is registered, so the pin and the status bit react one clock after the sample and limits that caused them.

Top module: `thermevt_ctrl`

## Requirements
- R1: The configuration register is at address 1, and its bit layout is as follows. Bit 0 is the mode (0 follow, 1 latch). Bit 1 is the pin level (0 low-active, 1 high-active). Bit 2 is critical-only. Bit 3 is output enable. Bit 4 is status (read-only). Bit 5 is clear (reads 0). Bit 6 is the alarm lock. Bit 7 is the critical lock. After reset every bit reads 0 and the pin is high.
- R2: A window violation means the temperature is above the upper limit or below the lower limit. A critical condition means the temperature is at or above the critical limit. All comparisons are signed.
- R3: In follow mode, the event flag takes the current condition at each clock edge. The pin and status show it one cycle after the sample.
- R4: In latch mode, the flag sets when the condition is present. It stays set after the temperature returns to range.
- R5: Writing 1 to bit 5 clears the flag only when latch mode is active before the write. If a condition is present in the same cycle, the clear wins for that cycle and the flag sets again at the next edge. In follow mode, the clear has no effect.
- R6: The pin drives the bit-1 level while the event is asserted and drives its inverse otherwise.
- R7: With critical-only set, window violations do not raise the event; critical conditions still do.
- R8: With output enable at 0, the pin holds the deasserted level. Status reads 1 only while the flag is set and the output is enabled.
- R9: While either lock bit is set, writes leave bits 0 and 1 unchanged, and other fields still update. A lock bit stays set until reset. A write is checked against the locks held before it.
- R10: Bits 15 to 8 read 0. Writes to them, to bit 4, and to any address other than 1 change nothing. Reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | TEMP_W | Signed temperature sample |
| upper_lim_i | input | TEMP_W | Signed upper window limit |
| lower_lim_i | input | TEMP_W | Signed lower window limit |
| crit_lim_i | input | TEMP_W | Signed critical limit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i |
| event_o | output | 1 | Event pin |

## Verification
The clear command and a fresh condition can land on the same clock edge in latch mode. The bench holds the temperature above the upper limit while writing the clear bit. It then expects the pin to show deasserted for exactly one cycle and asserted again the next cycle. A second collision is a lock bit being set in the same write that changes mode. The bench expects the mode to take the new value because the locks are judged before the write. A reference model updated on every clock checks both cases, and so do explicit expected pin values.

// File: rtl/thermevt_pkg.sv
package thermevt_pkg;

    localparam int REG_W    = 16;
    localparam int CFG_ADDR = 1;

    localparam int B_MODE   = 0;
    localparam int B_POL    = 1;
    localparam int B_CRITO  = 2;
    localparam int B_OE     = 3;
    localparam int B_STAT   = 4;
    localparam int B_CLR    = 5;
    localparam int B_ALOCK  = 6;
    localparam int B_CLOCK  = 7;
    localparam int USED_W   = 8;

    typedef enum logic {
        EVT_FOLLOW = 1'b0,
        EVT_LATCH  = 1'b1
    } evt_mode_e;

    typedef struct packed {
        logic      crit_lock;
        logic      alarm_lock;
        logic      out_en;
        logic      crit_only;
        logic      pol_high;
        evt_mode_e mode;
    } cfg_t;

    function automatic logic pin_level(input logic active, input logic pol_high);
        if (active) return pol_high;
        return ~pol_high;
    endfunction

endpackage

// File: rtl/thermevt_detect.sv
module thermevt_detect
    import thermevt_pkg::*;
#(
    parameter int TEMP_W = 13
) (
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic signed [TEMP_W-1:0] upper_lim_i,
    input  logic signed [TEMP_W-1:0] lower_lim_i,
    input  logic signed [TEMP_W-1:0] crit_lim_i,
    input  logic                     crit_only_i,
    output logic                     window_o,
    output logic                     crit_o,
    output logic                     cond_o
);

    always_comb begin
        window_o = (temp_i > upper_lim_i) || (temp_i < lower_lim_i);
        crit_o   = (temp_i >= crit_lim_i);
        cond_o   = crit_o || (window_o && !crit_only_i);
    end

endmodule

// File: rtl/thermevt_cfg.sv
module thermevt_cfg
    import thermevt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [USED_W-1:0] wdata_i,
    output cfg_t              cfg_o,
    output logic              clr_cmd_o
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CFG_ADDR);

    cfg_t cfg_q;
    logic wr_hit;
    logic locked;

    assign wr_hit = wr_en_i && (addr_i == HIT_ADDR);
    assign locked = cfg_q.alarm_lock || cfg_q.crit_lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_hit) begin
            if (!locked) begin
                cfg_q.mode     <= evt_mode_e'(wdata_i[B_MODE]);
                cfg_q.pol_high <= wdata_i[B_POL];
            end
            cfg_q.crit_only  <= wdata_i[B_CRITO];
            cfg_q.out_en     <= wdata_i[B_OE];
            cfg_q.alarm_lock <= cfg_q.alarm_lock | wdata_i[B_ALOCK];
            cfg_q.crit_lock  <= cfg_q.crit_lock  | wdata_i[B_CLOCK];
        end
    end

    assign cfg_o     = cfg_q;
    assign clr_cmd_o = wr_hit && wdata_i[B_CLR] && (cfg_q.mode == EVT_LATCH);

endmodule

// File: rtl/thermevt_flag.sv
module thermevt_flag
    import thermevt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_mode_e mode_i,
    input  logic      cond_i,
    input  logic      clr_i,
    input  logic      out_en_i,
    input  logic      pol_high_i,
    output logic      flag_o,
    output logic      status_o,
    output logic      event_o
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            case (mode_i)
                EVT_LATCH:  flag_q <= clr_i ? 1'b0 : (flag_q | cond_i);
                default:    flag_q <= cond_i;
            endcase
        end
    end

    assign flag_o   = flag_q;
    assign status_o = flag_q && out_en_i;
    assign event_o  = pin_level(status_o, pol_high_i);

endmodule

// File: rtl/thermevt_ctrl.sv
module thermevt_ctrl
    import thermevt_pkg::*;
#(
    parameter int TEMP_W = 13,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic signed [TEMP_W-1:0] upper_lim_i,
    input  logic signed [TEMP_W-1:0] lower_lim_i,
    input  logic signed [TEMP_W-1:0] crit_lim_i,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [REG_W-1:0]         wdata_i,
    output logic [REG_W-1:0]         rdata_o,
    output logic                     event_o
);

    localparam logic [ADDR_W-1:0] RD_ADDR = ADDR_W'(CFG_ADDR);

    cfg_t             cfg_q;
    logic             clr_cmd;
    logic             window_hit;
    logic             crit_hit;
    logic             cond;
    logic             flag_q;
    logic             status;
    logic [REG_W-1:0] reg_word;

    thermevt_detect #(.TEMP_W(TEMP_W)) u_detect (
        .temp_i      (temp_i),
        .upper_lim_i (upper_lim_i),
        .lower_lim_i (lower_lim_i),
        .crit_lim_i  (crit_lim_i),
        .crit_only_i (cfg_q.crit_only),
        .window_o    (window_hit),
        .crit_o      (crit_hit),
        .cond_o      (cond)
    );

    thermevt_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i[USED_W-1:0]),
        .cfg_o     (cfg_q),
        .clr_cmd_o (clr_cmd)
    );

    thermevt_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (cfg_q.mode),
        .cond_i     (cond),
        .clr_i      (clr_cmd),
        .out_en_i   (cfg_q.out_en),
        .pol_high_i (cfg_q.pol_high),
        .flag_o     (flag_q),
        .status_o   (status),
        .event_o    (event_o)
    );

    always_comb begin
        reg_word          = '0;
        reg_word[B_MODE]  = (cfg_q.mode == EVT_LATCH);
        reg_word[B_POL]   = cfg_q.pol_high;
        reg_word[B_CRITO] = cfg_q.crit_only;
        reg_word[B_OE]    = cfg_q.out_en;
        reg_word[B_STAT]  = status;
        reg_word[B_ALOCK] = cfg_q.alarm_lock;
        reg_word[B_CLOCK] = cfg_q.crit_lock;
    end

    assign rdata_o = (addr_i == RD_ADDR) ? reg_word : '0;

endmodule

// File: rtl/thermevt_ctrl_chk.sv
module thermevt_ctrl_chk
    import thermevt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input cfg_t             cfg_q,
    input logic             cond,
    input logic             crit_hit,
    input logic             window_hit,
    input logic             clr_cmd,
    input logic             flag_q,
    input logic             event_o,
    input logic             wr_en_i,
    input logic [REG_W-1:0] wdata_i,
    input logic [REG_W-1:0] reg_word
);

    logic locked;
    logic ignored_bits_set;
    assign locked           = cfg_q.alarm_lock || cfg_q.crit_lock;
    assign ignored_bits_set = (|wdata_i[REG_W-1:USED_W]) || wdata_i[B_STAT];

    a_r3_follow: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == EVT_FOLLOW) |=> (flag_q == $past(cond)));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.mode == EVT_LATCH) && flag_q && !clr_cmd) |=> flag_q);

    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.mode == EVT_LATCH) && clr_cmd) |=> !flag_q);

    a_r7_crit_only: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.mode == EVT_FOLLOW) && cfg_q.crit_only && window_hit && !crit_hit) |=> !flag_q);

    a_r8_disabled: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.out_en |-> (event_o == !cfg_q.pol_high));

    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(cfg_q.mode) && $stable(cfg_q.pol_high)));

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> (cfg_q.alarm_lock || cfg_q.crit_lock));

    a_r10_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && ignored_bits_set) |=>
            ((reg_word[REG_W-1:USED_W] == '0) && (reg_word[B_STAT] == (flag_q && cfg_q.out_en))));

endmodule

bind thermevt_ctrl thermevt_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_q      (cfg_q),
    .cond       (cond),
    .crit_hit   (crit_hit),
    .window_hit (window_hit),
    .clr_cmd    (clr_cmd),
    .flag_q     (flag_q),
    .event_o    (event_o),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .reg_word   (reg_word)
);

// File: tb/thermevt_ctrl_test.sv
module thermevt_ctrl_test;

    localparam int TW = 13;
    localparam int AW = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [TW-1:0] temp = 13'sd50;
    logic signed [TW-1:0] upper = 13'sd80;
    logic signed [TW-1:0] lower = 13'sd10;
    logic signed [TW-1:0] crit = 13'sd100;
    logic                 wr_en = 1'b0;
    logic [AW-1:0]        addr = 4'd1;
    logic [15:0]          wdata = 16'h0;
    logic [15:0]          rdata;
    logic                 evt;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit m_mode, m_pol, m_co, m_oe, m_al, m_cl, m_flag;

    thermevt_ctrl #(.TEMP_W(TW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .temp_i(temp), .upper_lim_i(upper),
        .lower_lim_i(lower), .crit_lim_i(crit), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .event_o(evt)
    );

    always #2.5 clk = ~clk;

    function automatic bit exp_event();
        return (m_flag && m_oe) ? m_pol : !m_pol;
    endfunction

    function automatic logic [15:0] exp_rdata();
        logic [15:0] w = '0;
        if (addr != 4'd1) return '0;
        w[0] = m_mode; w[1] = m_pol; w[2] = m_co; w[3] = m_oe;
        w[4] = m_flag && m_oe; w[6] = m_al; w[7] = m_cl;
        return w;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        int  t = temp;
        bit  win, crt, cond, hit, clr;
        if (rst) begin
            {m_mode, m_pol, m_co, m_oe, m_al, m_cl, m_flag} = '0;
            return;
        end
        win  = (t > int'(upper)) || (t < int'(lower));
        crt  = t >= int'(crit);
        cond = crt || (win && !m_co);
        hit  = wr_en && (addr == 4'd1);
        clr  = hit && wdata[5] && m_mode;
        if (m_mode) m_flag = clr ? 1'b0 : (m_flag || cond);
        else        m_flag = cond;
        if (hit) begin
            if (!(m_al || m_cl)) begin
                m_mode = wdata[0];
                m_pol  = wdata[1];
            end
            m_co = wdata[2];
            m_oe = wdata[3];
            m_al = m_al || wdata[6];
            m_cl = m_cl || wdata[7];
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " pin"}, {15'b0, evt}, {15'b0, exp_event()});
        chk({tag, " rdata"}, rdata, exp_rdata());
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d, string tag);
        wr_en = 1'b1; addr = a; wdata = d;
        step(tag);
        wr_en = 1'b0; addr = 4'd1; wdata = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step("R1 reset");
        step("R1 reset");
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        step("R1 idle");
        chk("R1 pin high", {15'b0, evt}, 16'h1);
        chk("R1 reg zero", rdata, 16'h0);

        wr(4'd1, 16'h0008, "R8 enable");
        temp = 13'sd90;  step("R3 above upper");
        chk("R2 above upper", {15'b0, evt}, 16'h0);
        temp = 13'sd50;  step("R3 back in range");
        chk("R3 follows", {15'b0, evt}, 16'h1);
        temp = 13'sd5;   step("R2 below lower");
        chk("R2 below lower", {15'b0, evt}, 16'h0);
        temp = 13'sd100; step("R2 critical");
        chk("R2 at critical", {15'b0, evt}, 16'h0);
        lower = -13'sd10; temp = -13'sd5; step("R2 signed");
        chk("R2 signed in range", {15'b0, evt}, 16'h1);
        temp = -13'sd20; step("R2 signed low");
        chk("R2 signed below", {15'b0, evt}, 16'h0);
        temp = 13'sd50;  step("R3");

        wr(4'd1, 16'h000A, "R6 high active");
        chk("R6 idle low", {15'b0, evt}, 16'h0);
        temp = 13'sd90;  step("R6 event");
        chk("R6 asserted high", {15'b0, evt}, 16'h1);

        wr(4'd1, 16'h000E, "R7 crit only");
        temp = 13'sd90;  step("R7 window masked");
        chk("R7 window masked", {15'b0, evt}, 16'h0);
        temp = 13'sd100; step("R7 critical");
        chk("R7 critical passes", {15'b0, evt}, 16'h1);
        temp = 13'sd99;  step("R7 below critical");
        chk("R7 below critical", {15'b0, evt}, 16'h0);

        temp = 13'sd50;
        wr(4'd1, 16'h0009, "R4 latch mode");
        temp = 13'sd90;  step("R4 trigger");
        temp = 13'sd50;  step("R4 hold");
        chk("R4 held", {15'b0, evt}, 16'h0);
        chk("R8 status set", {15'b0, rdata[4]}, 16'h1);
        step("R4 hold again");
        wr(4'd1, 16'h0029, "R5 clear");
        chk("R5 cleared", {15'b0, evt}, 16'h1);

        temp = 13'sd90;  step("R5 set");
        wr(4'd1, 16'h0029, "R5 collide");
        chk("R5 clear wins", {15'b0, evt}, 16'h1);
        step("R5 resets");
        chk("R5 sets again", {15'b0, evt}, 16'h0);

        wr(4'd1, 16'h0008, "R5 follow");
        wr(4'd1, 16'h0028, "R5 clear in follow");
        chk("R5 no effect in follow", {15'b0, evt}, 16'h0);

        wr(4'd1, 16'h0000, "R8 disable");
        chk("R8 pin deasserted", {15'b0, evt}, 16'h1);
        chk("R8 status clear", {15'b0, rdata[4]}, 16'h0);

        wr(4'd1, 16'hFF10, "R10 reserved write");
        chk("R10 reserved zero", rdata, 16'h0000);
        wr(4'd2, 16'h0008, "R10 other addr");
        chk("R10 other addr ignored", {15'b0, evt}, 16'h1);
        addr = 4'd2; step("R10 read other");
        chk("R10 other reads zero", rdata, 16'h0);
        addr = 4'd1;

        temp = 13'sd50;
        wr(4'd1, 16'h0049, "R9 lock with mode");
        chk("R9 mode set with lock", rdata, 16'h0049);
        wr(4'd1, 16'h000A, "R9 locked write");
        chk("R9 mode pol frozen", rdata, 16'h0049);
        wr(4'd1, 16'h0000, "R9 sticky");
        chk("R9 lock sticky", rdata, 16'h0041);

        do_reset();
        wr(4'd1, 16'h0080, "R9 crit lock");
        wr(4'd1, 16'h0003, "R9 crit locked write");
        chk("R9 crit lock freezes", rdata, 16'h0080);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule